// File: doc/BRIEF.md
# Row/Column Parity Word Corrector

This block guards a 64-bit word by treating it as an 8 x 8 bit matrix. Bit i of the word sits in row i/8 and column i%8. On the write side a purely combinational encoder produces 17 check bits. There is one even-parity bit per row, one per column, and a final bit that is the even parity of those sixteen. The word and its check bits are then stored by the surrounding memory.

On the read side the word and its stored check bits enter a decoder with a one-stage valid pipeline. The decoder recomputes the row and column parities and compares them with the stored ones. It also checks the stored parity bits against the stored corner bit. A single failing row that meets a single failing column points at one data bit, and that bit is inverted. A lone failing check bit is recognised and reported, and the data is left alone. Every other pattern is flagged as uncorrectable, and the word passes through unmodified.

Top module: `rowColEcc`

## Requirements
- R1: `encCheck[r]` (r = 0..7) equals the XOR of data bits 8r to 8r+7, which is even parity over row r.
- R2: `encCheck[8+c]` (c = 0..7) equals the XOR of every data bit i with i%8 == c, which is even parity over column c.
- R3: `encCheck[16]` equals the XOR of `encCheck[15:0]`.
- R4: During reset `outValid` is 0 and `outStatus` is 0. After reset, `outValid` equals `inValid` of the previous clock, and the decode result for a word sampled with `inValid` high appears on the outputs one clock later.
- R5: A word whose stored check bits all match gives `outStatus` = 0 (clean), and `outData` equals `rdData`.
- R6: When exactly one row check and exactly one column check fail and the corner check passes, the data bit at that row and column is inverted and `outStatus` = 1 (data corrected).
- R7: When the corner check fails and at most one row or column check fails, the error is taken to be in a stored check bit. In that case `outStatus` = 2 (check bit corrected) and `outData` equals `rdData`.
- R8: When the corner check passes and failures appear only among row checks, or only among column checks, `outStatus` = 3 (uncorrectable) and `outData` equals `rdData`.
- R9: When two or more rows and two or more columns fail, `outStatus` = 3 and `outData` equals `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encData | input | 64 | Word to be protected on the write side |
| encCheck | output | 17 | Check bits for `encData`: [7:0] rows, [15:8] columns, [16] corner |
| inValid | input | 1 | Read word and check bits are present |
| rdData | input | 64 | Word read from storage |
| rdCheck | input | 17 | Check bits read from storage, same layout as `encCheck` |
| outValid | output | 1 | Decode result valid |
| outData | output | 64 | Corrected or passed-through word |
| outStatus | output | 2 | 0 clean, 1 data corrected, 2 check bit corrected, 3 uncorrectable |

## Verification
The decoder is tried on clean all-zero and all-one words, on each of the 64 single data-bit flips and on each of the 17 single check-bit flips. These sweeps separate the data-correction path from the check-bit path and prove that every row and column index is steered correctly. Paired flips in one column and paired flips across two rows and two columns separate the two uncorrectable patterns from a false correction. Random words with zero to three random flips across all 81 stored bits, together with random encoder inputs, then compare every result against bench reference functions.

// File: rtl/rcePkg.sv
package rcePkg;
  localparam int ROWS   = 8;
  localparam int COLS   = 8;
  localparam int DATA_W = ROWS * COLS;
  localparam int CHK_W  = ROWS + COLS + 1;

  typedef enum logic [1:0] {
    ST_CLEAN     = 2'd0,
    ST_DATA_FIX  = 2'd1,
    ST_CHECK_FIX = 2'd2,
    ST_UNCORR    = 2'd3
  } rceStatus_e;

  // Strobes from the classifier to the datapath
  typedef struct packed {
    logic            fixData;
    logic [ROWS-1:0] rowSel;
    logic [COLS-1:0] colSel;
    rceStatus_e      status;
  } rceCtl_t;
endpackage

// File: rtl/rceParityGen.sv
module rceParityGen
  import rcePkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [ROWS-1:0]   rowPar,
  output logic [COLS-1:0]   colPar
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rowPar[r] = ^data[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] colBits;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign colBits[r] = data[r*COLS + c];
    end
    assign colPar[c] = ^colBits;
  end
endmodule

// File: rtl/rceControl.sv
module rceControl
  import rcePkg::*;
(
  input  logic [ROWS-1:0] rowSyn,
  input  logic [COLS-1:0] colSyn,
  input  logic            cornerSyn,
  output rceCtl_t         ctl
);
  int rowCnt;
  int colCnt;

  always_comb begin
    rowCnt      = $countones(rowSyn);
    colCnt      = $countones(colSyn);
    ctl.fixData = 1'b0;
    ctl.rowSel  = rowSyn;
    ctl.colSel  = colSyn;
    if (rowCnt == 0 && colCnt == 0 && !cornerSyn) begin
      ctl.status = ST_CLEAN;
    end else if (rowCnt == 1 && colCnt == 1 && !cornerSyn) begin
      ctl.status  = ST_DATA_FIX;
      ctl.fixData = 1'b1;
    end else if (cornerSyn && (rowCnt + colCnt) <= 1) begin
      ctl.status = ST_CHECK_FIX;
    end else begin
      ctl.status = ST_UNCORR;
    end
  end
endmodule

// File: rtl/rceDatapath.sv
module rceDatapath
  import rcePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  input  rceCtl_t           ctl,
  output logic [ROWS-1:0]   rowSyn,
  output logic [COLS-1:0]   colSyn,
  output logic              cornerSyn,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outStatus
);
  logic [ROWS-1:0]   rowNow;
  logic [COLS-1:0]   colNow;
  logic [DATA_W-1:0] flipMask;

  rceParityGen u_recalc (.data(rdData), .rowPar(rowNow), .colPar(colNow));

  assign rowSyn    = rowNow ^ rdCheck[ROWS-1:0];
  assign colSyn    = colNow ^ rdCheck[ROWS +: COLS];
  assign cornerSyn = (^rdCheck[ROWS+COLS-1:0]) ^ rdCheck[CHK_W-1];

  for (genvar r = 0; r < ROWS; r++) begin : g_fr
    for (genvar c = 0; c < COLS; c++) begin : g_fc
      assign flipMask[r*COLS + c] = ctl.fixData & ctl.rowSel[r] & ctl.colSel[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outStatus <= ST_CLEAN;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outData   <= rdData ^ flipMask;
        outStatus <= ctl.status;
      end
    end
  end

  p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_clean_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rowSyn == '0 && colSyn == '0 && !cornerSyn)
      |=> (outStatus == ST_CLEAN && outData == $past(rdData)));
  p_single_flip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == ST_DATA_FIX) |-> $countones(outData ^ $past(rdData)) == 1);
  p_check_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == ST_CHECK_FIX) |-> outData == $past(rdData));
  p_uncorr_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == ST_UNCORR) |-> outData == $past(rdData));
endmodule

// File: rtl/rowColEcc.sv
module rowColEcc
  import rcePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] encData,
  output logic [CHK_W-1:0]  encCheck,
  input  logic              inValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outStatus
);
  logic [ROWS-1:0] encRow;
  logic [COLS-1:0] encCol;
  logic [ROWS-1:0] rowSyn;
  logic [COLS-1:0] colSyn;
  logic            cornerSyn;
  rceCtl_t         ctl;

  rceParityGen u_enc (.data(encData), .rowPar(encRow), .colPar(encCol));
  assign encCheck = {^{encCol, encRow}, encCol, encRow};

  rceControl u_ctl (.rowSyn(rowSyn), .colSyn(colSyn), .cornerSyn(cornerSyn), .ctl(ctl));

  rceDatapath u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rdData(rdData), .rdCheck(rdCheck),
    .ctl(ctl), .rowSyn(rowSyn), .colSyn(colSyn), .cornerSyn(cornerSyn),
    .outValid(outValid), .outData(outData), .outStatus(outStatus)
  );

  always_comb begin
    p_corner_even_r3: assert (^encCheck == 1'b0);
  end
endmodule

// File: tb/tb_rowColEcc.sv
module tb_rowColEcc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] encData = '0;
  logic [16:0] encCheck;
  logic        inValid = 1'b0;
  logic [63:0] rdData = '0;
  logic [16:0] rdCheck = '0;
  logic        outValid;
  logic [63:0] outData;
  logic [1:0]  outStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rowColEcc dut (
    .clk(clk), .rstN(rstN), .encData(encData), .encCheck(encCheck),
    .inValid(inValid), .rdData(rdData), .rdCheck(rdCheck),
    .outValid(outValid), .outData(outData), .outStatus(outStatus)
  );

  function automatic logic [16:0] refCheck(input logic [63:0] d);
    logic [7:0] rp = '0;
    logic [7:0] cp = '0;
    for (int i = 0; i < 64; i++) begin
      rp[i/8] ^= d[i];
      cp[i%8] ^= d[i];
    end
    return {^{cp, rp}, cp, rp};
  endfunction

  function automatic void refDecode(input logic [63:0] d, input logic [16:0] ch,
                                    output logic [63:0] ed, output logic [1:0] es);
    logic [16:0] rc = refCheck(d);
    logic [7:0] rs = rc[7:0] ^ ch[7:0];
    logic [7:0] cs = rc[15:8] ^ ch[15:8];
    logic cn = (^ch[15:0]) ^ ch[16];
    int nr = 0, nc = 0, ri = 0, ci = 0;
    for (int k = 0; k < 8; k++) begin
      if (rs[k]) begin nr++; ri = k; end
      if (cs[k]) begin nc++; ci = k; end
    end
    ed = d;
    if (nr == 0 && nc == 0 && !cn) es = 2'd0;
    else if (nr == 1 && nc == 1 && !cn) begin es = 2'd1; ed[ri*8 + ci] = ~d[ri*8 + ci]; end
    else if (cn && nr + nc <= 1) es = 2'd2;
    else es = 2'd3;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic encodeOne(input logic [63:0] d);
    logic [16:0] e;
    encData = d;
    #1;
    e = refCheck(d);
    check(encCheck[7:0] == e[7:0], "R1", "row parity", 80'(encCheck[7:0]), 80'(e[7:0]));
    check(encCheck[15:8] == e[15:8], "R2", "col parity", 80'(encCheck[15:8]), 80'(e[15:8]));
    check(encCheck[16] == e[16], "R3", "corner", 80'(encCheck[16]), 80'(e[16]));
  endtask

  task automatic decodeOne(input logic [63:0] d, input logic [16:0] ch, input string req);
    logic [63:0] ed;
    logic [1:0] es;
    @(negedge clk);
    rdData = d; rdCheck = ch; inValid = 1'b1;
    refDecode(d, ch, ed, es);
    @(negedge clk);
    check(outValid == 1'b1, "R4", "valid after one clock", 80'(outValid), 80'(1));
    check(outStatus == es, req, "status", 80'(outStatus), 80'(es));
    check(outData == ed, req, "data", 80'(outData), 80'(ed));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [16:0] ch;
    logic [63:0] ed;
    logic [1:0] es;
    void'($urandom(32'h5eed));
    // R4 reset state
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R4", "reset valid", 80'(outValid), 80'(0));
    check(outStatus == 2'd0, "R4", "reset status", 80'(outStatus), 80'(0));
    rstN = 1'b1;

    encodeOne('0);
    encodeOne('1);
    encodeOne(64'h0000_0000_0000_0001);
    for (int n = 0; n < 300; n++) encodeOne({$urandom, $urandom});

    // R5 clean words
    decodeOne('0, refCheck('0), "R5");
    decodeOne('1, refCheck('1), "R5");
    d = 64'h0123_4567_89ab_cdef;
    decodeOne(d, refCheck(d), "R5");

    // R6 every single data bit
    for (int i = 0; i < 64; i++) begin
      d = {$urandom, $urandom};
      ch = refCheck(d);
      d[i] = ~d[i];
      decodeOne(d, ch, "R6");
    end

    // R7 every single check bit
    for (int i = 0; i < 17; i++) begin
      d = {$urandom, $urandom};
      ch = refCheck(d);
      ch[i] = ~ch[i];
      decodeOne(d, ch, "R7");
    end

    // R8 two flips in one column (rows only) and two in one row (columns only)
    d = 64'hdead_beef_cafe_f00d;
    ch = refCheck(d);
    decodeOne(d ^ 64'h101, ch, "R8");
    decodeOne(d ^ 64'h3, ch, "R8");

    // R9 two rows and two columns
    decodeOne(d ^ 64'h201, ch, "R9");
    decodeOne(d ^ 64'h8000_0000_0000_0201, ch, "R9");

    // R4 valid drops after a gap
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R4", "valid low after idle", 80'(outValid), 80'(0));

    // Random words with 0..3 flips among the 81 stored bits
    for (int n = 0; n < 400; n++) begin
      logic [80:0] word;
      int nf;
      d = {$urandom, $urandom};
      word = {refCheck(d), d};
      nf = $urandom_range(0, 3);
      for (int k = 0; k < nf; k++) word[$urandom_range(0, 80)] ^= 1'b1;
      refDecode(word[63:0], word[80:64], ed, es);
      case (es)
        2'd0: decodeOne(word[63:0], word[80:64], "R5");
        2'd1: decodeOne(word[63:0], word[80:64], "R6");
        2'd2: decodeOne(word[63:0], word[80:64], "R7");
        default: decodeOne(word[63:0], word[80:64], "R9");
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule